// File: doc/BRIEF.md
# Memory-Mapped Dual GPIO Port Controller

This peripheral hangs on a byte-wide CPU bus and provides two general-purpose I/O ports. The wide port has eight pins. Each of its pins is push-pull and has its own direction bit. The narrow port has two open-drain pins. Those two pins can be handed over as a pair to an I2C controller, which then uses them as its data line and its clock line. Every pad is modelled as three separate signals: the value to drive, an output enable, and the sampled input level. The wide port also has a pull-up enable for each pin.

Software writes the registers through a single-cycle write strobe. It reads them back through a combinational read-data path. Every pad input passes through a two-flop synchronizer before any read-back logic sees it, and before it is forwarded to the I2C controller. The block uses an asynchronous active-low reset. After reset, all wide-port pins are inputs with their pull-ups on, and both open-drain pins are released.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted and after reset, every wide-port pin is an input: pa_oe = 0x00 and pa_pu = 0xFF. Both open-drain pins are released (pb_oe = 0). The alternate-function enable reads back high, so the narrow port is in GPIO mode.
- R2: Address 0x02 holds the wide-port direction register. A write there takes effect at the clock edge that samples the write strobe. A direction bit of 0 makes the matching pin an output (pa_oe bit 1), and a bit of 1 makes it an input. Reading 0x02 returns 0xFF.
- R3: Address 0x03 holds the wide-port data latch. An output pin drives its latched data bit on pa_out. The pull-up flag pa_pu is 1 exactly for the pins that are inputs.
- R4: Reading 0x03 returns, for each bit, the synchronized pad level when that pin is an input, and the latched data bit when it is an output.
- R5: A pad input change is seen at the read-back and forwarding paths after exactly two rising clock edges, and not after one.
- R6: Address 0x04 holds the narrow-port data latch in bits 1:0. In GPIO mode, latch bit 0 drives the pin low (pb_oe bit 1) and latch bit 1 releases it. pb_out is always 0.
- R7: Reading 0x04 returns the synchronized narrow-port pad levels in bits 1:0 and ones in bits 7:2.
- R8: Bit 7 of the control register at address 0x29 is an active-low alternate-function enable. Reading 0x29 returns that bit in bit 7 and ones in bits 6:0. While the bit is 0, pb_oe[0] follows i2c_sda_drive_low and pb_oe[1] follows i2c_scl_drive_low, and the narrow-port data latch has no effect on the pads.
- R9: i2c_sda_in and i2c_scl_in always carry the synchronized levels of narrow-port pins 0 and 1, in both modes.
- R10: A read of any address other than 0x02, 0x03, 0x04 or 0x29 returns 0xFF. A write to such an address changes no register.
- R11: When bus_we is low, no register changes, whatever values are on bus_addr and bus_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pa_in | input | 8 | Wide-port pad input levels |
| pa_out | output | 8 | Wide-port pad drive values |
| pa_oe | output | 8 | Wide-port pad output enables |
| pa_pu | output | 8 | Wide-port pull-up enables |
| pb_in | input | 2 | Narrow-port pad input levels |
| pb_out | output | 2 | Narrow-port pad drive values (always low) |
| pb_oe | output | 2 | Narrow-port pull-low enables |
| i2c_sda_drive_low | input | 1 | I2C controller request to pull the data line low |
| i2c_scl_drive_low | input | 1 | I2C controller request to pull the clock line low |
| i2c_sda_in | output | 1 | Synchronized data-line level for the I2C controller |
| i2c_scl_in | output | 1 | Synchronized clock-line level for the I2C controller |

## Verification
The assertions assume three things about the inputs. First, bus_we is a single-cycle strobe whose bus_addr and bus_wdata are stable around the sampling edge. Second, pad levels are treated as asynchronous, so the only property tied to them is the fixed two-edge latency of the synchronizer. Third, the I2C drive-low requests may change in any cycle. The bench keeps to these assumptions. It changes every input only at falling clock edges. It draws addresses mostly from the four mapped locations, with some arbitrary bytes mixed in. It randomizes the pad levels and the drive-low requests in every cycle, and it switches between GPIO and alternate mode through ordinary writes to the control register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_AW = 8;

  localparam logic [BUS_AW-1:0] ADDR_PP_DIR  = 8'h02;
  localparam logic [BUS_AW-1:0] ADDR_PP_DATA = 8'h03;
  localparam logic [BUS_AW-1:0] ADDR_OD_DATA = 8'h04;
  localparam logic [BUS_AW-1:0] ADDR_CTRL    = 8'h29;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PP_DIR,
    SEL_PP_DATA,
    SEL_OD_DATA,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int              W       = 8,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q = stg_q[STAGES-1];

  // cycles since reset, saturating, used only to guard the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (q == $past(d, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_pp_port.sv
module gpio_pp_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_dir,
  input  logic         we_data,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] dat_q, dat_d;
  logic [W-1:0] in_sync;

  gpio_sync #(.W(W), .STAGES(2), .RST_VAL({W{1'b1}})) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (in_sync)
  );

  always_comb begin
    dir_d = dir_q;
    dat_d = dat_q;
    if (we_dir)  dir_d = wdata;
    if (we_data) dat_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      dat_q <= '1;
    end else begin
      dir_q <= dir_d;
      dat_q <= dat_d;
    end
  end

  assign pad_oe  = ~dir_q;
  assign pad_pu  = dir_q;
  assign pad_out = dat_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_rd
      assign rd_data[i] = dir_q[i] ? in_sync[i] : dat_q[i];
    end
  endgenerate

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir |=> (pad_oe == ~$past(wdata)));

  assert_drive_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_data |=> (pad_out == $past(wdata)));

  assert_readback_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data ^ pad_out) & pad_oe) == '0);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_dir && !we_data) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_data,
  input  logic         we_ctl,
  input  logic [W-1:0] wdata,
  input  logic         ctl_wbit,
  input  logic [W-1:0] alt_drive_low,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] alt_in,
  output logic [W-1:0] rd_data,
  output logic         alt_en_n
);
  logic [W-1:0] lat_q, lat_d;
  logic         en_n_q, en_n_d;
  logic [W-1:0] in_sync;

  gpio_sync #(.W(W), .STAGES(2), .RST_VAL({W{1'b1}})) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (in_sync)
  );

  always_comb begin
    lat_d  = lat_q;
    en_n_d = en_n_q;
    if (we_data) lat_d  = wdata;
    if (we_ctl)  en_n_d = ctl_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '1;
      en_n_q <= 1'b1;
    end else begin
      lat_q  <= lat_d;
      en_n_q <= en_n_d;
    end
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pad
      assign pad_oe[i] = en_n_q ? ~lat_q[i] : alt_drive_low[i];
    end
  endgenerate

  assign alt_en_n = en_n_q;
  assign alt_in   = in_sync;
  assign rd_data  = in_sync;

  assert_od_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_data && alt_en_n && !we_ctl) |=> (pad_oe == ~$past(wdata)));

  assert_alt_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ctl && !ctl_wbit) |=> (pad_oe == alt_drive_low));

  assert_gpio_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ctl && ctl_wbit && !we_data) |=> (pad_oe == ~$past(lat_q)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_data && !we_ctl) |=> ($stable(lat_q) && $stable(alt_en_n)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OD_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  output logic [DATA_W-1:0] pa_pu,
  input  logic [OD_W-1:0]   pb_in,
  output logic [OD_W-1:0]   pb_out,
  output logic [OD_W-1:0]   pb_oe,
  input  logic              i2c_sda_drive_low,
  input  logic              i2c_scl_drive_low,
  output logic              i2c_sda_in,
  output logic              i2c_scl_in
);
  localparam int PAD_HI = DATA_W - OD_W;
  localparam int CTL_HI = DATA_W - 1;

  reg_sel_e          sel;
  logic [DATA_W-1:0] pp_rd;
  logic [OD_W-1:0]   od_rd;
  logic [OD_W-1:0]   od_alt_in;
  logic              alt_en_n;

  always_comb begin
    case (bus_addr)
      ADDR_PP_DIR:  sel = SEL_PP_DIR;
      ADDR_PP_DATA: sel = SEL_PP_DATA;
      ADDR_OD_DATA: sel = SEL_OD_DATA;
      ADDR_CTRL:    sel = SEL_CTRL;
      default:      sel = SEL_NONE;
    endcase
  end

  gpio_pp_port #(.W(DATA_W)) i_pp (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_dir (bus_we && (sel == SEL_PP_DIR)),
    .we_data(bus_we && (sel == SEL_PP_DATA)),
    .wdata  (bus_wdata),
    .pad_in (pa_in),
    .pad_out(pa_out),
    .pad_oe (pa_oe),
    .pad_pu (pa_pu),
    .rd_data(pp_rd)
  );

  gpio_od_port #(.W(OD_W)) i_od (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_data      (bus_we && (sel == SEL_OD_DATA)),
    .we_ctl       (bus_we && (sel == SEL_CTRL)),
    .wdata        (bus_wdata[OD_W-1:0]),
    .ctl_wbit     (bus_wdata[CTL_HI]),
    .alt_drive_low({i2c_scl_drive_low, i2c_sda_drive_low}),
    .pad_in       (pb_in),
    .pad_oe       (pb_oe),
    .alt_in       (od_alt_in),
    .rd_data      (od_rd),
    .alt_en_n     (alt_en_n)
  );

  assign pb_out     = '0;
  assign i2c_sda_in = od_alt_in[0];
  assign i2c_scl_in = od_alt_in[1];

  always_comb begin
    case (sel)
      SEL_PP_DATA: bus_rdata = pp_rd;
      SEL_OD_DATA: bus_rdata = {{PAD_HI{1'b1}}, od_rd};
      SEL_CTRL:    bus_rdata = {alt_en_n, {CTL_HI{1'b1}}};
      default:     bus_rdata = '1;
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (pa_oe == '0 && pa_pu == '1 && pb_oe == '0);
    end
  end

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_PP_DATA && bus_addr != ADDR_OD_DATA && bus_addr != ADDR_CTRL)
      |-> (bus_rdata == '1));

  assert_i2c_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_OD_DATA) |-> (bus_rdata[OD_W-1:0] == {i2c_scl_in, i2c_sda_in}));
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'hFF, pa_out, pa_oe, pa_pu;
  logic [1:0] pb_in = 2'b11, pb_out, pb_oe;
  logic       sda_dl = 1'b0, scl_dl = 1'b0, sda_in, scl_in;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pa_pu(pa_pu), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .i2c_sda_drive_low(sda_dl), .i2c_scl_drive_low(scl_dl),
    .i2c_sda_in(sda_in), .i2c_scl_in(scl_in)
  );

  // reference state, built from the requirements
  logic [7:0] m_dir, m_dat, pa_s1, pa_s2;
  logic [1:0] m_pb, pb_s1, pb_s2;
  logic       m_en_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir <= 8'hFF; m_dat <= 8'hFF; m_pb <= 2'b11; m_en_n <= 1'b1;
      pa_s1 <= 8'hFF; pa_s2 <= 8'hFF; pb_s1 <= 2'b11; pb_s2 <= 2'b11;
    end else begin
      pa_s1 <= pa_in; pa_s2 <= pa_s1;
      pb_s1 <= pb_in; pb_s2 <= pb_s1;
      if (bus_we) begin
        case (bus_addr)
          8'h02: m_dir <= bus_wdata;
          8'h03: m_dat <= bus_wdata;
          8'h04: m_pb <= bus_wdata[1:0];
          8'h29: m_en_n <= bus_wdata[7];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h03: exp_rd = (m_dir & pa_s2) | (~m_dir & m_dat);
      8'h04: exp_rd = {6'h3F, pb_s2};
      8'h29: exp_rd = {m_en_n, 7'h7F};
      default: exp_rd = 8'hFF;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h02: rd_tag = "R2";
      8'h03: rd_tag = "R4";
      8'h04: rd_tag = "R7";
      8'h29: rd_tag = "R8";
      default: rd_tag = "R10";
    endcase
  endfunction

  function automatic logic [1:0] exp_pb_oe();
    exp_pb_oe = m_en_n ? ~m_pb : {scl_dl, sda_dl};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk(rd_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
    chk("R2", pa_oe, ~m_dir);
    chk("R3", pa_pu, m_dir);
    chk("R3", pa_out & pa_oe, m_dat & ~m_dir);
    chk(m_en_n ? "R6" : "R8", {6'd0, pb_oe}, {6'd0, exp_pb_oe()});
    chk("R6", {6'd0, pb_out}, 8'h00);
    chk("R9", {6'd0, scl_in, sda_in}, {6'd0, pb_s2});
  endtask

  // drive at a falling edge, check combinational outputs, then let one edge pass
  task automatic step(input logic [7:0] a, input logic we, input logic [7:0] wd);
    bus_addr = a; bus_we = we; bus_wdata = wd;
    #1;
    check_all();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] wd);
    step(a, 1'b1, wd);
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    case (r % 6)
      0: pick_addr = 8'h02;
      1: pick_addr = 8'h03;
      2: pick_addr = 8'h04;
      3: pick_addr = 8'h29;
      default: pick_addr = 8'($urandom);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1", pa_oe, 8'h00);
    chk("R1", pa_pu, 8'hFF);
    chk("R1", {6'd0, pb_oe}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = 8'h29; #1;
    chk("R1", bus_rdata, 8'hFF);
    bus_addr = 8'h04; #1;
    chk("R1", bus_rdata, 8'hFF);
    @(negedge clk);

    // R2: direction write makes pins outputs; address 0x02 reads 0xFF
    wr(8'h03, 8'hC3);
    wr(8'h02, 8'h0F);
    step(8'h02, 1'b0, 8'h00);
    chk("R2", pa_oe, 8'hF0);
    chk("R3", pa_out & 8'hF0, 8'hC0);
    chk("R2", bus_rdata, 8'hFF);

    // R5: two-edge latency of pad sampling on an input bit
    pa_in = 8'h5A;
    repeat (3) step(8'h03, 1'b0, 8'h00);
    pa_in = 8'hA5;
    bus_addr = 8'h03; #1;
    chk("R5", bus_rdata, 8'hCA);
    @(negedge clk); #1;
    chk("R5", bus_rdata, 8'hCA);
    @(negedge clk); #1;
    chk("R5", bus_rdata, 8'hC5);
    @(negedge clk);

    // R11: strobe low leaves every register alone
    step(8'h02, 1'b0, 8'hFF);
    step(8'h03, 1'b0, 8'h00);
    step(8'h29, 1'b0, 8'h00);
    chk("R11", pa_oe, 8'hF0);
    chk("R11", pa_out & 8'hF0, 8'hC0);

    // R10: write to an unmapped address changes nothing
    wr(8'h05, 8'h00);
    step(8'h05, 1'b0, 8'h00);
    chk("R10", bus_rdata, 8'hFF);
    chk("R10", pa_oe, 8'hF0);

    // R6: open-drain pin 0 pulled low, pin 1 released
    wr(8'h04, 8'h02);
    step(8'h04, 1'b0, 8'h00);
    chk("R6", {6'd0, pb_oe}, 8'h01);

    // R8: alternate mode ignores the latch and follows the I2C requests
    wr(8'h29, 8'h7F);
    sda_dl = 1'b0; scl_dl = 1'b1;
    step(8'h29, 1'b0, 8'h00);
    chk("R8", {6'd0, pb_oe}, 8'h02);
    chk("R8", bus_rdata, 8'h7F);
    wr(8'h04, 8'h00);
    step(8'h04, 1'b0, 8'h00);
    chk("R8", {6'd0, pb_oe}, 8'h02);
    wr(8'h29, 8'hFF);
    step(8'h04, 1'b0, 8'h00);
    chk("R6", {6'd0, pb_oe}, 8'h03);

    // R9/R7: narrow-port levels forwarded and read back
    pb_in = 2'b01;
    repeat (3) step(8'h04, 1'b0, 8'h00);
    chk("R7", bus_rdata, 8'hFD);
    chk("R9", {6'd0, scl_in, sda_in}, 8'h01);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      pa_in  = 8'($urandom);
      pb_in  = 2'($urandom);
      sda_dl = 1'($urandom);
      scl_dl = 1'($urandom);
      step(pick_addr($urandom), ($urandom % 3) == 0, 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule